// File: doc/BRIEF.md
# Smart Card Character Wait Timer

This block watches the gaps between characters on an asynchronous smart card link. A counter advances once per elementary time unit (etu) tick and restarts whenever a new character begins. If the gap since the last character start grows past a limit, the block raises a sticky wait-error flag.

The limit depends on the protocol in use. In T=0 the limit is sixty times an 8-bit wait setting. In T=1 it is the setting itself, in etu. Software clears the flag by writing a zero to it. Changing the protocol selection restarts the measurement, so switching the selection away and back drops a pending timeout. While reception is disabled the counter rests at zero and no new error can arise. When reception is enabled again, the gap is measured from that moment, so a timeout after re-enable lands later than one measured from the last character.

Top module: `char_wait_timer`

## Requirements
- R1: After reset `wait_err` reads 0.
- R2: With `proto_sel` = 0 (T=0), after a character start with `rx_en` = 1, `wait_err` becomes 1 once more than 60 × `wait_set` etu ticks have arrived without a new start. A start that follows exactly 60 × `wait_set` ticks leaves the flag at 0.
- R3: With `proto_sel` = 1 (T=1), the same rule holds with a limit of `wait_set` ticks: `wait_set` + 1 ticks set the flag, and a start after exactly `wait_set` ticks does not.
- R4: A `char_start` pulse while `rx_en` = 1 restarts the gap count from zero.
- R5: A write with `flag_wr_en` = 1 and `flag_wr_data` = 0 clears a set flag, unless a new timeout is being detected in the same cycle. A write of 1 leaves the flag unchanged.
- R6: While `rx_en` = 0, the flag keeps its value, the count is held at zero, and no new error is set. After `rx_en` rises, the gap is measured from the rise.
- R7: Any change of `proto_sel` restarts the gap count from zero.
- R8: The count saturates at its maximum instead of wrapping. An idle period of any length keeps the timeout condition true, so a clearing write issued then does not clear the flag.
- R9: Once set, the flag stays at 1 through further character starts and idle time until reset or a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| char_start | input | 1 | One-cycle pulse at the start of each character |
| proto_sel | input | 1 | Protocol selection: 0 = T=0, 1 = T=1 |
| rx_en | input | 1 | Receive enable |
| wait_set | input | 8 | Wait setting in etu (scaled by 60 in T=0) |
| flag_wr_en | input | 1 | CPU write strobe for the flag |
| flag_wr_data | input | 1 | CPU write value for the flag |
| wait_err | output | 1 | Sticky wait-error flag |

## Verification
The gap count is hidden. A wrong count shows up only as a flag that rises one tick early or late, or one that never rises, and it appears one cycle after the tick that crosses the limit. A missed restart, from a character start or a protocol change, shows as a false error a few ticks later. A count that wraps instead of saturating shows as a flag that a clearing write can remove after a long idle period. The tests therefore place character starts exactly at the limit and one tick past it, and they issue clearing writes both while the timeout condition holds and after a restart.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

    typedef enum logic {
        PROTO_T0 = 1'b0,
        PROTO_T1 = 1'b1
    } proto_e;

    function automatic int unsigned limit_bits(int unsigned set_w, int unsigned mult);
        return $clog2(mult * ((1 << set_w) - 1) + 1);
    endfunction

endpackage

// File: rtl/cwt_limit.sv
module cwt_limit #(
    parameter int unsigned SET_W   = 8,
    parameter int unsigned T0_MULT = 60,
    parameter int unsigned LIM_W   = cwt_pkg::limit_bits(SET_W, T0_MULT)
) (
    input  logic             proto_sel,
    input  logic [SET_W-1:0] wait_set,
    output logic [LIM_W-1:0] limit_o
);
    import cwt_pkg::*;

    logic [LIM_W-1:0] set_ext;
    logic [LIM_W-1:0] scaled;

    always_comb begin
        set_ext = LIM_W'(wait_set);
        scaled  = set_ext * LIM_W'(T0_MULT);
        limit_o = (proto_e'(proto_sel) == PROTO_T1) ? set_ext : scaled;
    end

endmodule

// File: rtl/cwt_counter.sv
module cwt_counter #(
    parameter int unsigned LIM_W = 14,
    parameter int unsigned CNT_W = LIM_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             etu_tick,
    input  logic             char_start,
    input  logic             proto_sel,
    input  logic             rx_en,
    input  logic [LIM_W-1:0] limit_i,
    output logic             over_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             proto;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       proto_chg;

    always_comb begin
        st_d       = st_q;
        st_d.proto = proto_sel;
        proto_chg  = (proto_sel != st_q.proto);
        if (!rx_en || proto_chg || char_start) begin
            st_d.cnt = '0;
        end else if (etu_tick && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        over_o = rx_en && !proto_chg && (st_q.cnt > CNT_W'(limit_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (st_q.cnt == '0)); // R6
    AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && char_start) |=> (st_q.cnt == '0)); // R4
    AST_PROTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_sel != $past(proto_sel)) |=> (st_q.cnt == '0)); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX || st_q.cnt == '0)); // R8

endmodule

// File: rtl/cwt_flag.sv
module cwt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en,
    input  logic wr_data,
    output logic err_o
);
    typedef struct packed {
        logic err;
    } flag_state_t;

    flag_state_t fl_d, fl_q;
    logic        clr_req;

    always_comb begin
        fl_d    = fl_q;
        clr_req = wr_en && !wr_data && fl_q.err;
        if (set_i) begin
            fl_d.err = 1'b1;
        end else if (clr_req) begin
            fl_d.err = 1'b0;
        end
        err_o = fl_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.err && !(wr_en && !wr_data)) |=> fl_q.err); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.err && wr_en && !wr_data && !set_i) |=> !fl_q.err); // R5
    AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.err) |-> $past(set_i)); // R2

endmodule

// File: rtl/char_wait_timer.sv
module char_wait_timer #(
    parameter int unsigned SET_W   = 8,
    parameter int unsigned T0_MULT = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             etu_tick,
    input  logic             char_start,
    input  logic             proto_sel,
    input  logic             rx_en,
    input  logic [SET_W-1:0] wait_set,
    input  logic             flag_wr_en,
    input  logic             flag_wr_data,
    output logic             wait_err
);
    localparam int unsigned LIM_W = cwt_pkg::limit_bits(SET_W, T0_MULT);
    localparam int unsigned CNT_W = LIM_W + 1;

    logic [LIM_W-1:0] limit;
    logic             over;

    cwt_limit #(
        .SET_W   (SET_W),
        .T0_MULT (T0_MULT),
        .LIM_W   (LIM_W)
    ) i_limit (
        .proto_sel (proto_sel),
        .wait_set  (wait_set),
        .limit_o   (limit)
    );

    cwt_counter #(
        .LIM_W (LIM_W),
        .CNT_W (CNT_W)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .etu_tick   (etu_tick),
        .char_start (char_start),
        .proto_sel  (proto_sel),
        .rx_en      (rx_en),
        .limit_i    (limit),
        .over_o     (over)
    );

    cwt_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (over),
        .wr_en   (flag_wr_en),
        .wr_data (flag_wr_data),
        .err_o   (wait_err)
    );

    AST_NO_ERR_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !wait_err) |=> !wait_err); // R6
    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_en && flag_wr_data && wait_err) |=> wait_err); // R5

endmodule

// File: tb/test_char_wait_timer.sv
module test_char_wait_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       etu_tick = 1'b0;
    logic       char_start = 1'b0;
    logic       proto_sel = 1'b1;
    logic       rx_en = 1'b0;
    logic [7:0] wait_set = 8'd5;
    logic       flag_wr_en = 1'b0;
    logic       flag_wr_data = 1'b0;
    logic       wait_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    char_wait_timer i_char_wait_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .etu_tick     (etu_tick),
        .char_start   (char_start),
        .proto_sel    (proto_sel),
        .rx_en        (rx_en),
        .wait_set     (wait_set),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .wait_err     (wait_err)
    );

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (wait_err !== exp) begin
            n_bad++;
            $display("FAIL %s: wait_err actual %b expected %b at %0t", req, wait_err, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        etu_tick = 1'b1;
        repeat (n) @(negedge clk);
        etu_tick = 1'b0;
    endtask

    task automatic start_char();
        char_start = 1'b1;
        @(negedge clk);
        char_start = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        flag_wr_en   = 1'b1;
        flag_wr_data = v;
        @(negedge clk);
        flag_wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", 1'b0);
    endtask

    task automatic t_t1_limit();
        proto_sel = 1'b1; wait_set = 8'd5; rx_en = 1'b1; idle(1);
        start_char(); ticks(5); start_char(); idle(2);
        check("R3 exact limit", 1'b0);
        ticks(6); idle(1);
        check("R3 over limit", 1'b1);
        start_char(); idle(3);
        check("R9 sticky after start", 1'b1);
        wr_flag(1'b1);
        check("R5 write one keeps", 1'b1);
        wr_flag(1'b0);
        check("R5 write zero clears", 1'b0);
        wr_flag(1'b1);
        check("R5 write one on clear flag", 1'b0);
    endtask

    task automatic t_t0_limit();
        proto_sel = 1'b0; wait_set = 8'd2; idle(1);
        start_char(); ticks(120); start_char(); idle(2);
        check("R2 exact limit", 1'b0);
        ticks(121); idle(1);
        check("R2 over limit", 1'b1);
        start_char(); wr_flag(1'b0);
        check("R2 cleared", 1'b0);
    endtask

    task automatic t_restart();
        proto_sel = 1'b1; wait_set = 8'd5; idle(1);
        start_char(); ticks(4); start_char(); ticks(4); idle(2);
        check("R4 restart by start", 1'b0);
    endtask

    task automatic t_proto_toggle();
        start_char(); ticks(4);
        proto_sel = 1'b0; idle(1);
        proto_sel = 1'b1; idle(1);
        ticks(4); idle(2);
        check("R7 toggle restarts", 1'b0);
        ticks(2); idle(1);
        check("R7 count from toggle", 1'b1);
        start_char(); wr_flag(1'b0);
    endtask

    task automatic t_rx_off();
        start_char(); ticks(6); idle(1);
        check("R6 setup", 1'b1);
        rx_en = 1'b0; idle(3);
        check("R6 flag kept when disabled", 1'b1);
        ticks(20);
        wr_flag(1'b0);
        check("R6 clear while disabled", 1'b0);
        ticks(20); idle(2);
        check("R6 no new error while disabled", 1'b0);
        rx_en = 1'b1;
        ticks(5); idle(2);
        check("R6 measured from enable", 1'b0);
        ticks(1); idle(1);
        check("R6 timeout after enable", 1'b1);
        start_char(); wr_flag(1'b0);
    endtask

    task automatic t_saturate();
        proto_sel = 1'b0; wait_set = 8'd255; idle(1);
        start_char(); ticks(40000); idle(2);
        check("R8 long idle", 1'b1);
        wr_flag(1'b0);
        check("R8 no wrap, clear refused", 1'b1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_t1_limit();
        t_t0_limit();
        t_restart();
        t_proto_toggle();
        t_rx_off();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule